// File: doc/BRIEF.md
# Prescaled Time-Base Counter with Latch Read

This block produces the common time base of a timer subsystem. A 14-bit main prescaler divides either the system clock or a synchronous external clock enable. Each time its count runs out, it emits a one-cycle tick. That tick advances a 33-bit up-counter. Software can freeze all 33 bits into a snapshot register with a single write, and then read the snapshot in pieces without tearing. The main tick also drives a second 14-bit prescaler. Its one-cycle tick advances a 24-bit real-time up-counter. Both ticks leave the block for use by neighbouring timers.

Each prescaler is a two-state machine. In `PS_ARMED` the count is zero, and the next enabled cycle fires a tick. In `PS_WAIT` the count is non-zero and falls by one per enabled cycle. The transitions are as follows. FIRE_RELOAD goes from ARMED to WAIT: it fires and reloads a non-zero divisor. FIRE_STAY keeps ARMED: it fires with a divisor of zero. LAST_STEP goes from WAIT to ARMED: the count falls from 1 to 0. STEP keeps WAIT: the count falls but stays above zero. CLEAR goes from any state to ARMED: a divisor write forces the count to zero. Every write and read goes through a flat 16-bit register port.

Top module: `tbase_timer`

## Requirements
- R1: With divisor D and the prescaler input enabled every cycle, a tick occurs exactly once every D+1 cycles. The main divisor is at address 0 and the real-time divisor is at address 9, each in bits [13:0].
- R2: A tick is high for exactly one cycle. It rises only in the cycle after an enabled cycle in which the prescaler count was zero.
- R3: Any write to a divisor address clears that prescaler's count to zero. The tick follows in the cycle after the next enabled cycle.
- R4: The 33-bit main counter increases by one per main tick. It wraps from all ones to zero.
- R5: Software writes to the main counter replace only the addressed piece: bits [15:0] at address 2, bits [31:16] at address 3, bit 32 at address 4 (data bit 0). Counting resumes from the written value. Reads at the same addresses return the live count.
- R6: When a counter write and a tick fall in the same cycle, the written value is kept and that tick adds nothing.
- R7: Any write to address 5 copies all 33 main counter bits into a snapshot. The snapshot reads back at addresses 6, 7 and 8, in the same 16/16/1 split as the live count. It does not change until the next such write.
- R8: Address 1, bit 0, selects the main prescaler's enable: 0 enables it every system cycle, 1 follows the ext_en input. While ext_en is low, no main tick occurs.
- R9: The real-time prescaler advances only on main ticks and emits rt_tick by the rule of R1 and R2.
- R10: The 24-bit real-time counter increases by one per rt_tick and wraps to zero. Its bits [15:0] are at address 10 and bits [23:16] are at address 11. These addresses are writable like R5 and have no snapshot.
- R11: During reset both ticks are low, and all counters and divisors read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_en | input | 1 | External count enable, already synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| tb_tick | output | 1 | Main time-base tick |
| rt_tick | output | 1 | Real-time tick |

## Verification
The main counter can receive a software piece write and a main tick in the same cycle. The bench sets up this collision in external-enable mode with a zero divisor. It pulses ext_en for one cycle, so the resulting tick lands exactly on the edge that applies the write. The counter must then read back the written value, not the value plus one. The same setup without a write confirms that an isolated tick still increments. A snapshot taken just before further ticks confirms that the latched copy stays put while the live count moves.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    typedef enum logic [3:0] {
        A_MDIV = 4'd0,
        A_SRC  = 4'd1,
        A_MC0  = 4'd2,
        A_MC1  = 4'd3,
        A_MC2  = 4'd4,
        A_SNAP = 4'd5,
        A_SN0  = 4'd6,
        A_SN1  = 4'd7,
        A_SN2  = 4'd8,
        A_RDIV = 4'd9,
        A_RC0  = 4'd10,
        A_RC1  = 4'd11
    } reg_addr_e;

    typedef enum logic {
        PS_ARMED = 1'b0,
        PS_WAIT  = 1'b1
    } ps_state_e;

endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler
    import tbase_pkg::*;
#(
    parameter int DIV_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_in,
    input  logic [DIV_W-1:0] div,
    input  logic             clr,
    output logic             tick
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    ps_state_e        state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic             fire;
    logic             tick_q;

    // next-state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        if (clr) begin
            state_d = PS_ARMED;               // CLEAR
            cnt_d   = '0;
        end else if (en_in) begin
            unique case (state_q)
                PS_ARMED: begin
                    fire    = 1'b1;
                    cnt_d   = div;
                    state_d = (div == '0) ? PS_ARMED : PS_WAIT; // FIRE_STAY / FIRE_RELOAD
                end
                PS_WAIT: begin
                    cnt_d   = cnt_q - ONE;
                    state_d = (cnt_q == ONE) ? PS_ARMED : PS_WAIT; // LAST_STEP / STEP
                end
                default: state_d = PS_ARMED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // registered output
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= fire;
    end

    assign tick = tick_q;

    p_tick_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |-> ($past(en_in) && !$past(clr) && $past(cnt_q) == '0));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && !tick_q));

    p_state_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_ARMED) == (cnt_q == '0));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_in && !clr) |=> ($stable(cnt_q) && !tick_q));

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (tick) cnt_q <= cnt_q + W'(1);
    end

    assign cnt = cnt_q;

    p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt_q != '1) |=> cnt_q == $past(cnt_q) + W'(1));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt_q == '1) |=> cnt_q == '0);

    p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
    import tbase_pkg::*;
#(
    parameter int DIV_W  = 14,
    parameter int MAIN_W = 33,
    parameter int RT_W   = 24,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              tb_tick,
    output logic              rt_tick
);

    localparam int MTOP_W = MAIN_W - 2 * DATA_W;
    localparam int RTOP_W = RT_W - DATA_W;

    logic [DIV_W-1:0]  mdiv_q, rdiv_q;
    logic              src_q;
    logic [MAIN_W-1:0] snap_q;
    logic [MAIN_W-1:0] main_cnt, main_ld_val;
    logic [RT_W-1:0]   rt_cnt, rt_ld_val;
    logic              main_ld, rt_ld, snap_cmd, mclr, rclr, m_en;

    // write decode
    always_comb begin
        mclr        = wr_en && (wr_addr == A_MDIV);
        rclr        = wr_en && (wr_addr == A_RDIV);
        snap_cmd    = wr_en && (wr_addr == A_SNAP);
        main_ld     = wr_en && (wr_addr == A_MC0 || wr_addr == A_MC1 || wr_addr == A_MC2);
        rt_ld       = wr_en && (wr_addr == A_RC0 || wr_addr == A_RC1);
        main_ld_val = main_cnt;
        rt_ld_val   = rt_cnt;
        case (wr_addr)
            A_MC0:   main_ld_val[DATA_W-1:0]             = wr_data;
            A_MC1:   main_ld_val[2*DATA_W-1:DATA_W]      = wr_data;
            A_MC2:   main_ld_val[MAIN_W-1:2*DATA_W]      = wr_data[MTOP_W-1:0];
            A_RC0:   rt_ld_val[DATA_W-1:0]               = wr_data;
            A_RC1:   rt_ld_val[RT_W-1:DATA_W]            = wr_data[RTOP_W-1:0];
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdiv_q <= '0;
            rdiv_q <= '0;
            src_q  <= 1'b0;
            snap_q <= '0;
        end else begin
            if (mclr)     mdiv_q <= wr_data[DIV_W-1:0];
            if (rclr)     rdiv_q <= wr_data[DIV_W-1:0];
            if (wr_en && wr_addr == A_SRC) src_q <= wr_data[0];
            if (snap_cmd) snap_q <= main_cnt;
        end
    end

    assign m_en = src_q ? ext_en : 1'b1;

    tbase_prescaler #(.DIV_W(DIV_W)) u_main_ps (
        .clk(clk), .rst_n(rst_n), .en_in(m_en), .div(mdiv_q), .clr(mclr), .tick(tb_tick)
    );

    tbase_prescaler #(.DIV_W(DIV_W)) u_rt_ps (
        .clk(clk), .rst_n(rst_n), .en_in(tb_tick), .div(rdiv_q), .clr(rclr), .tick(rt_tick)
    );

    tbase_counter #(.W(MAIN_W)) u_main_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tb_tick), .load(main_ld),
        .load_val(main_ld_val), .cnt(main_cnt)
    );

    tbase_counter #(.W(RT_W)) u_rt_cnt (
        .clk(clk), .rst_n(rst_n), .tick(rt_tick), .load(rt_ld),
        .load_val(rt_ld_val), .cnt(rt_cnt)
    );

    // read mux
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_MDIV:  rd_data = DATA_W'(mdiv_q);
            A_SRC:   rd_data = DATA_W'(src_q);
            A_MC0:   rd_data = main_cnt[DATA_W-1:0];
            A_MC1:   rd_data = main_cnt[2*DATA_W-1:DATA_W];
            A_MC2:   rd_data = DATA_W'(main_cnt[MAIN_W-1:2*DATA_W]);
            A_SN0:   rd_data = snap_q[DATA_W-1:0];
            A_SN1:   rd_data = snap_q[2*DATA_W-1:DATA_W];
            A_SN2:   rd_data = DATA_W'(snap_q[MAIN_W-1:2*DATA_W]);
            A_RDIV:  rd_data = DATA_W'(rdiv_q);
            A_RC0:   rd_data = rt_cnt[DATA_W-1:0];
            A_RC1:   rd_data = DATA_W'(rt_cnt[RT_W-1:DATA_W]);
            default: rd_data = '0;
        endcase
    end

    p_snap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snap_cmd |=> snap_q == $past(main_cnt));

    p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_cmd |=> $stable(snap_q));

    p_rt_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rt_tick |-> $past(tb_tick));

    p_collision_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (main_ld && tb_tick) |=> main_cnt == $past(main_ld_val));

endmodule

// File: tb/test_tbase_timer.sv
module test_tbase_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        tb_tick, rt_tick;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    tbase_timer i_tbase_timer (
        .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tb_tick(tb_tick), .rt_tick(rt_tick)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_ext();
        @(negedge clk);
        ext_en = 1'b1;
        @(negedge clk);
        ext_en = 1'b0;
    endtask

    // R11: reset state
    task automatic t_reset();
        logic [15:0] d;
        @(negedge clk);
        chk("R11 tb_tick", tb_tick, 0);
        chk("R11 rt_tick", rt_tick, 0);
        rd(4'd2, d);  chk("R11 main low", d, 0);
        rd(4'd4, d);  chk("R11 main top", d, 0);
        rd(4'd10, d); chk("R11 rt low", d, 0);
        rd(4'd0, d);  chk("R11 main div", d, 0);
    endtask

    // R1, R2: period and pulse width on system clock
    task automatic t_period();
        int n; int dbl; logic prev;
        wr(4'd1, 16'd0);
        wr(4'd0, 16'd4);
        idle(6);
        n = 0; dbl = 0; prev = 1'b0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (tb_tick) n++;
            if (tb_tick && prev) dbl++;
            prev = tb_tick;
        end
        chk("R1 ticks in 50 cycles div 4", n, 10);
        chk("R2 back-to-back ticks", dbl, 0);
        wr(4'd0, 16'd0);
        idle(2);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tb_tick) n++;
        end
        chk("R1 ticks in 20 cycles div 0", n, 20);
    endtask

    // R3: divisor write clears the count mid-period
    task automatic t_clear();
        int k;
        wr(4'd0, 16'd100);
        idle(20);
        chk("R3 no tick mid-count", tb_tick, 0);
        wr(4'd0, 16'd100);
        chk("R3 tick low on clear edge", tb_tick, 0);
        @(negedge clk);
        chk("R3 tick right after clear", tb_tick, 1);
        k = 0;
        for (int i = 1; i <= 200; i++) begin
            @(negedge clk);
            if (tb_tick) begin k = i; break; end
        end
        chk("R3 R1 next tick after 101", k, 101);
    endtask

    // R8, R4, R5, R6: external enable, wrap and collision
    task automatic t_ext_count();
        logic [15:0] d; int n;
        wr(4'd1, 16'd1);
        wr(4'd0, 16'd0);
        idle(3);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tb_tick) n++;
        end
        chk("R8 no tick with ext_en low", n, 0);
        wr(4'd2, 16'h0005); wr(4'd3, 16'h0000); wr(4'd4, 16'h0000);
        rd(4'd2, d); chk("R5 low piece write", d, 16'h0005);
        pulse_ext(); idle(2);
        rd(4'd2, d); chk("R4 single tick increments", d, 16'h0006);
        // collision: tick high on the edge that applies the write
        @(negedge clk);
        ext_en = 1'b1;
        @(negedge clk);
        ext_en = 1'b0;
        chk("R6 tick present in collision cycle", tb_tick, 1);
        wr_en = 1'b1; wr_addr = 4'd2; wr_data = 16'h1234;
        @(negedge clk);
        wr_en = 1'b0;
        idle(2);
        rd(4'd2, d); chk("R6 write wins over tick", d, 16'h1234);
        // wrap at maximum
        wr(4'd2, 16'hFFFF); wr(4'd3, 16'hFFFF); wr(4'd4, 16'h0001);
        rd(4'd4, d); chk("R5 top bit write", d, 16'h0001);
        pulse_ext(); idle(2);
        rd(4'd2, d); chk("R4 wrap low", d, 0);
        rd(4'd3, d); chk("R4 wrap mid", d, 0);
        rd(4'd4, d); chk("R4 wrap top", d, 0);
        // ext held high, div 3
        wr(4'd0, 16'd3);
        @(negedge clk); ext_en = 1'b1;
        idle(4);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tb_tick) n++;
        end
        ext_en = 1'b0;
        chk("R8 R1 ticks with ext_en high div 3", n, 10);
    endtask

    // R7: snapshot stays while live count moves
    task automatic t_snapshot();
        logic [15:0] d;
        wr(4'd0, 16'd0);
        wr(4'd2, 16'h1234); wr(4'd3, 16'hABCD); wr(4'd4, 16'h0001);
        wr(4'd5, 16'h0000);
        pulse_ext(); idle(2);
        rd(4'd6, d); chk("R7 snap low", d, 16'h1234);
        rd(4'd7, d); chk("R7 snap mid", d, 16'hABCD);
        rd(4'd8, d); chk("R7 snap top", d, 16'h0001);
        rd(4'd2, d); chk("R7 live moved on", d, 16'h1235);
    endtask

    // R9, R10: real-time chain
    task automatic t_rt();
        logic [15:0] d; int n;
        wr(4'd1, 16'd0);
        wr(4'd0, 16'd1);
        wr(4'd9, 16'd2);
        idle(12);
        n = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (rt_tick) n++;
        end
        chk("R9 rt ticks in 60 cycles", n, 10);
        // counter matches observed rt ticks
        wr(4'd1, 16'd1);
        idle(12);
        wr(4'd10, 16'h0000); wr(4'd11, 16'h0000);
        n = 0;
        @(negedge clk); ext_en = 1'b1;
        for (int i = 0; i < 70; i++) begin
            @(negedge clk);
            if (i == 50) ext_en = 1'b0;
            if (rt_tick) n++;
        end
        rd(4'd10, d); chk("R10 rt counter equals rt ticks", d, n);
        // wrap
        wr(4'd0, 16'd0); wr(4'd9, 16'd0);
        wr(4'd10, 16'hFFFF); wr(4'd11, 16'h00FF);
        rd(4'd11, d); chk("R10 rt high write", d, 16'h00FF);
        pulse_ext(); idle(4);
        rd(4'd10, d); chk("R10 rt wrap low", d, 0);
        rd(4'd11, d); chk("R10 rt wrap high", d, 0);
    endtask

    initial begin
        t_reset();
        idle(2);
        rst_n = 1'b1;
        t_period();
        t_clear();
        t_ext_count();
        t_snapshot();
        t_rt();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule